// File: doc/BRIEF.md
# Serial PCS Receive Carrier-Sense and Code-Group Aligner

This block sits behind line decoding in a 100BASE-X style receiver. It takes one decoded code bit per bit clock and decides when a frame has begun. The idle line carries continuous ones. As soon as the bit stream shows two zeros that are separated by at least one one, the block raises carrier sense and its receiving flag. Three bits later it has the whole idle/start-delimiter pattern in view. It then either locks the 5-bit code-group boundary or withdraws the carrier as a false carrier.

Once locked, the block delivers one aligned 5-bit code group every five bit clocks on a valid strobe. A normal end-of-stream pair stops the stream cleanly. If the stream instead decays into idle without that pair, the block flags a receive error before going quiet. The output stream has no ready input: code bits arrive at line rate and cannot be held back. The consumer must therefore take each group in the single cycle its strobe is high. The group stays on the data pins until the next strobe, but it is only defined while the strobe is high.

Top module: `pcs_rx_carrier`

## Requirements
- R1: With `rst` high at a clock edge, after that edge `crs`, `rx_er`, `receiving` and `grp_valid` are all low and the block is idle. This holds also in the middle of a frame.
- R2: While idle, the block raises `receiving` after the edge at which it samples a 0 under three conditions: the bit sampled one edge earlier was 1, and at least one of the 8 bits sampled before those two was 0. No earlier edge raises it.
- R3: `crs` equals `receiving` in every cycle.
- R4: An all-ones line, isolated single zeros more than 10 bits apart, and a lone run of contiguous zeros never raise `crs`.
- R5: The block checks the 15 bits ending three bits after carrier detection. If they are idle 11111, then J 11000, then K 10001 (oldest bit first, each group MSB first), it enters the receive state with `rx_er` low.
- R6: If those 15 bits differ from that pattern, `rx_er` goes high for exactly 5 clocks while `crs` stays high. After that, `crs`, `receiving` and `rx_er` all return low together.
- R7: In the receive state, `grp_valid` pulses for one cycle on every fifth clock. The pulse comes in the cycle after the fifth bit of a group is sampled. `grp_data` then holds that group with its first-arriving bit in bit 4. The first group delivered is the one that follows K.
- R8: A T group (01101) followed directly by an R group (00111) ends the stream. `receiving` drops in the same cycle as the strobe that delivers R, and `rx_er` stays low. A T group followed by anything else does not end the stream.
- R9: Two consecutive idle groups (11111) in the receive state are both delivered. Starting with the strobe of the second one, `rx_er` is high for 5 clocks with `crs` held high. Then all three flags go low.
- R10: `grp_valid` is never high unless `receiving` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one code bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Decoded serial code bit |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error (false carrier or premature end) |
| receiving | output | 1 | Receiving flag |
| grp_data | output | 5 | Aligned code group, first bit received in bit 4 |
| grp_valid | output | 1 | One-cycle strobe qualifying `grp_data` |

## Verification
A wrong boundary phase shows up at the first strobe after K. The delivered groups come out rotated against the transmitted ones, and the strobe falls on the wrong cycle. A detection window of the wrong length shows up within ten bits of a stray zero, either as a carrier that is never raised or as a spurious `crs` pulse. Errors in the exit or error counters show up as an `rx_er` pulse that is not five cycles long, or as a `receiving` flag that outlives the R strobe by a cycle. Each of these is caught in the cycle it happens, because a bit-level model is compared against every output on every clock.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  // code-group width in bits
  localparam int GW = 5;

  // line code groups, first-arriving bit in the MSB
  localparam logic [GW-1:0] CG_IDLE = 5'b11111;
  localparam logic [GW-1:0] CG_J    = 5'b11000;
  localparam logic [GW-1:0] CG_K    = 5'b10001;
  localparam logic [GW-1:0] CG_T    = 5'b01101;
  localparam logic [GW-1:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CARR = 2'd1,
    ST_RECV = 2'd2,
    ST_ERR  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pcs_rx_shifter.sv
module pcs_rx_shifter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  output logic [W-1:0] win
);
  logic [W-2:0] hist_q;

  // history resets to the idle level so no stale zero can trigger detection
  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= {hist_q[W-3:0], bit_in};
  end

  // window includes the bit being sampled at this edge in position 0
  assign win = {hist_q, bit_in};
endmodule

// File: rtl/pcs_rx_detect.sv
module pcs_rx_detect
  import pcs_rx_pkg::*;
#(
  parameter int DET_WIN = 10,
  parameter int SYNC_W  = 3 * GW
) (
  input  logic [SYNC_W-1:0] win,
  output logic              carrier_hit,
  output logic              sync_ok,
  output logic [GW-1:0]     grp_now
);
  localparam logic [SYNC_W-1:0] SYNC_PAT = {CG_IDLE, CG_J, CG_K};

  logic older_zero;

  // any zero in the older part of the detection window
  assign older_zero  = |(~win[DET_WIN-1:2]);
  // a fresh zero after a one, with an earlier separated zero
  assign carrier_hit = !win[0] && win[1] && older_zero;
  assign sync_ok     = (win == SYNC_PAT);
  assign grp_now     = win[GW-1:0];
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          carrier_hit,
  input  logic          sync_ok,
  input  logic [GW-1:0] grp_now,
  output logic          recv_o,
  output logic          err_o,
  output logic [GW-1:0] data_o,
  output logic          vld_o
);
  // detection fires on K's second bit; the rest of K is still to come
  localparam int LOOK = GW - 2;
  localparam int CW   = $clog2(GW);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] prev_q;
  logic          recv_q, err_q, vld_q;
  logic [GW-1:0] data_q;
  logic          grp_end, end_clean, end_idle;

  assign grp_end   = (cnt_q == CW'(GW - 1));
  assign end_clean = (prev_q == CG_T) && (grp_now == CG_R);
  assign end_idle  = (prev_q == CG_IDLE) && (grp_now == CG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      prev_q <= '0;
      recv_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (carrier_hit) begin
            st_q   <= ST_CARR;
            cnt_q  <= '0;
            recv_q <= 1'b1;
          end
        end
        ST_CARR: begin
          if (cnt_q == CW'(LOOK - 1)) begin
            cnt_q <= '0;
            if (sync_ok) begin
              st_q   <= ST_RECV;
              prev_q <= CG_K;
            end else begin
              st_q  <= ST_ERR;
              err_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (grp_end) begin
            cnt_q  <= '0;
            vld_q  <= 1'b1;
            data_q <= grp_now;
            prev_q <= grp_now;
            if (end_clean) begin
              st_q   <= ST_IDLE;
              recv_q <= 1'b0;
            end else if (end_idle) begin
              st_q  <= ST_ERR;
              err_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ERR: begin
          if (grp_end) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            err_q  <= 1'b0;
            recv_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign recv_o = recv_q;
  assign err_o  = err_q;
  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/pcs_rx_carrier.sv
module pcs_rx_carrier
  import pcs_rx_pkg::*;
#(
  parameter int DET_WIN = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_bit,
  output logic          crs,
  output logic          rx_er,
  output logic          receiving,
  output logic [GW-1:0] grp_data,
  output logic          grp_valid
);
  localparam int SYNC_W = 3 * GW;
  localparam int HIST_W = (SYNC_W > DET_WIN) ? SYNC_W : DET_WIN;

  logic [HIST_W-1:0] win;
  logic              carrier_hit, sync_ok, recv_w;
  logic [GW-1:0]     grp_now;

  pcs_rx_shifter #(.W(HIST_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .bit_in (rx_bit),
    .win    (win)
  );

  pcs_rx_detect #(.DET_WIN(DET_WIN), .SYNC_W(SYNC_W)) u_det (
    .win         (win[SYNC_W-1:0]),
    .carrier_hit (carrier_hit),
    .sync_ok     (sync_ok),
    .grp_now     (grp_now)
  );

  pcs_rx_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .carrier_hit (carrier_hit),
    .sync_ok     (sync_ok),
    .grp_now     (grp_now),
    .recv_o      (recv_w),
    .err_o       (rx_er),
    .data_o      (grp_data),
    .vld_o       (grp_valid)
  );

  assign receiving = recv_w;
  assign crs       = recv_w;
endmodule

// File: rtl/pcs_rx_carrier_chk.sv
module pcs_rx_carrier_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_bit,
  input logic       crs,
  input logic       rx_er,
  input logic       receiving,
  input logic [4:0] grp_data,
  input logic       grp_valid
);
  // consecutive cycles of rx_er seen before the current sample
  logic [3:0] er_run;
  always_ff @(posedge clk) begin
    if (rst)        er_run <= '0;
    else if (rx_er) er_run <= er_run + 1'b1;
    else            er_run <= '0;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!crs && !rx_er && !receiving && !grp_valid));

  a_r2_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(receiving) |-> !$past(rx_bit));

  a_r6_er_under_carrier: assert property (@(posedge clk) disable iff (rst)
    rx_er |-> crs);

  a_r6_er_not_long: assert property (@(posedge clk) disable iff (rst)
    rx_er |-> (er_run < 4'd5));

  a_r6_er_full_len: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_er) |-> (er_run == 4'd5));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    grp_valid |=> !grp_valid);

  a_r8_clean_end_strobe: assert property (@(posedge clk) disable iff (rst)
    ($fell(receiving) && !$past(rx_er)) |-> grp_valid);

  a_r10_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> $past(receiving));
endmodule

bind pcs_rx_carrier pcs_rx_carrier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_bit    (rx_bit),
  .crs       (crs),
  .rx_er     (rx_er),
  .receiving (receiving),
  .grp_data  (grp_data),
  .grp_valid (grp_valid)
);

// File: tb/pcs_rx_carrier_tb_top.sv
module pcs_rx_carrier_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       crs, rx_er, receiving, grp_valid;
  logic [4:0] grp_data;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit finished = 0;

  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
  localparam logic [4:0] T_ = 5'b01101, R_ = 5'b00111;

  always #2 clk = ~clk;

  pcs_rx_carrier dut_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .crs(crs), .rx_er(rx_er),
    .receiving(receiving), .grp_data(grp_data), .grp_valid(grp_valid)
  );

  // ---------------- behavioural reference model ----------------
  bit         hist[$];
  int         m_mode, m_n;
  bit         m_recv, m_er, m_vld;
  logic [4:0] m_data, m_prev;

  function automatic logic [14:0] last15();
    logic [14:0] v;
    for (int i = 0; i < 15; i++) v[14-i] = hist[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = {};
      for (int i = 0; i < 15; i++) hist.push_back(1'b1);
      m_mode = 0; m_n = 0; m_recv = 0; m_er = 0; m_vld = 0;
      m_data = '0; m_prev = '0;
    end else begin
      int zeros;
      logic [4:0] g;
      hist.push_back(rx_bit);
      void'(hist.pop_front());
      m_vld = 0;
      case (m_mode)
        0: begin
          zeros = 0;
          for (int i = 5; i <= 12; i++) if (!hist[i]) zeros++;
          if (!hist[14] && hist[13] && zeros > 0) begin
            m_mode = 1; m_n = 0; m_recv = 1;
          end
        end
        1: begin
          m_n++;
          if (m_n == 3) begin
            m_n = 0;
            if (last15() == {I_, J_, K_}) begin m_mode = 2; m_prev = K_; end
            else begin m_mode = 3; m_er = 1; end
          end
        end
        2: begin
          m_n++;
          if (m_n == 5) begin
            m_n = 0;
            g = last15();
            m_vld = 1; m_data = g;
            if (m_prev == T_ && g == R_) begin m_mode = 0; m_recv = 0; end
            else if (m_prev == I_ && g == I_) begin m_mode = 3; m_er = 1; end
            m_prev = g;
          end
        end
        default: begin
          m_n++;
          if (m_n == 5) begin m_n = 0; m_mode = 0; m_er = 0; m_recv = 0; end
        end
      endcase
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison and monitors, away from the active edge
  logic [4:0] got[$];
  int er_cyc = 0, crs_cyc = 0;

  always @(negedge clk) begin
    if (chk_on) begin
      chk(crs == m_recv, "R2", "crs vs model", crs, m_recv);
      chk(crs == receiving, "R3", "crs vs receiving", crs, receiving);
      chk(rx_er == m_er, "R6", "rx_er vs model", rx_er, m_er);
      chk(grp_valid == m_vld, "R7", "grp_valid vs model", grp_valid, m_vld);
      if (m_vld) chk(grp_data == m_data, "R7", "grp_data vs model", grp_data, m_data);
      if (grp_valid) got.push_back(grp_data);
      if (rx_er) er_cyc++;
      if (crs) crs_cyc++;
    end
  end

  task automatic send_bit(logic b);
    rx_bit = b;
    @(negedge clk);
  endtask
  task automatic send_grp(logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask
  task automatic idle(int n);
    repeat (n) send_bit(1'b1);
  endtask
  task automatic clear_mon();
    got = {}; er_cyc = 0; crs_cyc = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_q[$];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;
    // R1 reset state
    chk(!crs && !rx_er && !receiving && !grp_valid, "R1", "flags after reset",
        {crs, rx_er, receiving, grp_valid}, 0);

    // R4 isolated zeros and a contiguous run never raise carrier
    clear_mon();
    idle(20); send_bit(0); idle(15); send_bit(0); idle(15);
    send_bit(0); send_bit(0); send_bit(0); idle(20);
    chk(crs_cyc == 0, "R4", "crs cycles on sparse zeros", crs_cyc, 0);

    // R2 R5 R7 R8 normal frame
    clear_mon();
    send_grp(J_); send_bit(1);
    chk(crs == 0, "R2", "crs before second separated zero", crs, 0);
    send_bit(0);
    chk(crs == 1, "R2", "crs after second separated zero", crs, 1);
    send_bit(0); send_bit(0); send_bit(1);
    exp_q = {5'b01110, 5'b10100, 5'b11110, 5'b01011, T_, R_};
    foreach (exp_q[i]) send_grp(exp_q[i]);
    chk(receiving == 0, "R8", "receiving after T R", receiving, 0);
    idle(20);
    chk(er_cyc == 0, "R5", "rx_er cycles in clean frame", er_cyc, 0);
    chk(got.size() == exp_q.size(), "R7", "groups delivered", got.size(), exp_q.size());
    foreach (exp_q[i]) if (i < got.size())
      chk(got[i] == exp_q[i], "R7", "delivered group", got[i], exp_q[i]);

    // R6 false carrier
    clear_mon();
    send_bit(0); send_bit(1); send_bit(0); idle(20);
    chk(er_cyc == 5, "R6", "false carrier rx_er length", er_cyc, 5);
    chk(got.size() == 0, "R10", "groups during false carrier", got.size(), 0);
    chk(crs == 0, "R6", "crs after false carrier", crs, 0);

    // R8 T not followed by R keeps the stream
    clear_mon();
    send_grp(J_); send_grp(K_);
    exp_q = {T_, 5'b01110, T_, R_};
    foreach (exp_q[i]) send_grp(exp_q[i]);
    idle(20);
    chk(got.size() == 4, "R8", "groups with lone T", got.size(), 4);
    chk(er_cyc == 0, "R8", "rx_er with lone T", er_cyc, 0);

    // R9 premature end on two idle groups
    clear_mon();
    send_grp(J_); send_grp(K_);
    send_grp(5'b10100); send_grp(5'b01010); send_grp(I_); send_grp(I_);
    idle(20);
    chk(er_cyc == 5, "R9", "rx_er length on idle end", er_cyc, 5);
    chk(got.size() == 4, "R9", "groups on idle end", got.size(), 4);
    if (got.size() == 4) chk(got[3] == I_, "R9", "last group idle", got[3], I_);
    chk(crs == 0, "R9", "crs after idle end", crs, 0);

    // R1 reset in mid-frame
    clear_mon();
    send_grp(J_); send_grp(K_); send_grp(5'b01110); send_bit(0);
    rst = 1'b1; send_bit(1); send_bit(1);
    chk(!crs && !rx_er && !receiving && !grp_valid, "R1", "flags after mid-frame reset",
        {crs, rx_er, receiving, grp_valid}, 0);
    rst = 1'b0; idle(20);

    // back-to-back frame after recovery
    clear_mon();
    send_grp(J_); send_grp(K_); send_grp(5'b11100); send_grp(T_); send_grp(R_); idle(15);
    chk(got.size() == 3, "R7", "groups after reset recovery", got.size(), 3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule